// File: doc/BRIEF.md
# Serial Link Request Frame Decoder

This block sits on the receiving end of a one-wire request line. A requester shifts a frame onto that line one bit per clock. The decoder samples the line on every rising clock edge and waits for a start bit. It collects the request type that follows. From the type it works out how many field bits come next: a bus request carries a speed code, a register read carries an address, and a register write carries an address and a data byte. It then checks the closing stop bit and presents the decoded request as a one-cycle strobe, together with held field outputs.

The frame length is not known until the third type bit has arrived. The state machine therefore loads its bit counter at the moment the type is complete, using the payload length of that type. Malformed traffic raises one of two error pulses:

- A reserved type code raises the type-error pulse.
- A stop bit received high raises the framing-error pulse.

In both cases the decoder then ignores the line until it sees a low sample.

The state machine has five states:

- HUNT: the idle state. A high sample goes to TYPE.
- TYPE: collects three type bits. After the third bit it goes to BODY for a defined code, or to DRAIN for a reserved code.
- BODY: collects the payload bits. After the last payload bit it goes to STOP.
- STOP: samples the stop bit. A low sample goes to HUNT and emits the strobe. A high sample goes to DRAIN and raises the framing error.
- DRAIN: waits out junk on the line. A low sample goes to HUNT.

Top module: `lreq_frame_decoder`

## Requirements
- R1: An asynchronous active-low reset clears every output to zero at once and puts the decoder in HUNT.
- R2: A bus request frame is 7 bits long: a 1 start bit, a 3-bit type, a 2-bit speed and a 0 stop bit. The type codes are 000 immediate, 001 isochronous, 010 priority and 011 fair. The strobe rises in the cycle after the stop bit is sampled, with the speed output set and the address and data outputs zero.
- R3: A register read frame is 9 bits long, with type 100 and a 4-bit address. Its strobe reports the address, with the speed and data outputs zero.
- R4: A register write frame is 17 bits long, with type 101, a 4-bit address and then an 8-bit data byte. Its strobe reports both the address and the data, with the speed output zero.
- R5: Every field is sent most significant bit first, and the type output shows the received 3-bit code.
- R6: Type codes 110 and 111 are reserved. A reserved code raises the type-error pulse for one cycle, in the cycle after the third type bit is sampled. No strobe follows. High samples after the code are ignored until one low sample has been seen.
- R7: A stop bit sampled high raises the framing-error pulse for one cycle, in the cycle after that sample. No strobe is produced for the frame. High samples that follow are ignored until one low sample has been seen.
- R8: The type, speed, address and data outputs hold their values from one strobe to the next. Idle time and errors do not change them.
- R9: A start bit in the cycle right after a stop bit begins a new frame. Frames sent back to back all decode.
- R10: A line held at zero produces no strobe and no error.
- R11: Each good frame produces exactly one strobe, and that strobe lasts one cycle. At most one of the strobe and the two error pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lreq_in | input | 1 | Serial request line, idle low |
| req_valid_o | output | 1 | One-cycle strobe for a good frame |
| req_type_o | output | 3 | Decoded request type code |
| req_speed_o | output | SPD_W (2) | Speed code of a bus request |
| reg_addr_o | output | ADDR_W (4) | Register address of a read or write |
| reg_data_o | output | DATA_W (8) | Data byte of a write |
| type_err_o | output | 1 | One-cycle pulse for a reserved type code |
| frame_err_o | output | 1 | One-cycle pulse for a stop bit received high |

## Verification
The hardest case to reach from the ports is the frame boundary with no gap between frames. Here the stop sample of one frame and the start sample of the next fall on adjacent edges, so STOP must hand over to HUNT with no spare cycle. The stimulus table sends most of its frames back to back, across all three frame lengths. A monitor timestamps every strobe so that each one can be compared against the cycle predicted from its stop bit. Directed runs follow a reserved code and a bad stop bit with a run of high samples, and then a good frame right after a single low sample. These runs show that DRAIN swallows the junk and still releases the line in time for the next frame.

// File: rtl/lrq_pkg.sv
package lrq_pkg;
    localparam int TYPE_W = 3;
    localparam logic [TYPE_W-1:0] CODE_RD = 3'b100;
    localparam logic [TYPE_W-1:0] CODE_WR = 3'b101;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_TYPE,
        ST_BODY,
        ST_STOP,
        ST_DRAIN
    } lrq_state_e;

    typedef enum logic [1:0] {
        K_BUS,
        K_READ,
        K_WRITE,
        K_RSVD
    } lrq_kind_e;
endpackage

// File: rtl/lrq_classify.sv
module lrq_classify
    import lrq_pkg::*;
#(
    parameter int SPD_W  = 2,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic [TYPE_W-1:0] code_i,
    output lrq_kind_e         kind_o,
    output logic [CNT_W-1:0]  last_o
);
    // Payload length minus one, chosen by the type code.
    always_comb begin
        kind_o = K_RSVD;
        last_o = '0;
        if (!code_i[TYPE_W-1]) begin
            kind_o = K_BUS;
            last_o = CNT_W'(SPD_W - 1);
        end else if (code_i == CODE_RD) begin
            kind_o = K_READ;
            last_o = CNT_W'(ADDR_W - 1);
        end else if (code_i == CODE_WR) begin
            kind_o = K_WRITE;
            last_o = CNT_W'(ADDR_W + DATA_W - 1);
        end
    end
endmodule

// File: rtl/lrq_shifter.sv
module lrq_shifter
    import lrq_pkg::*;
#(
    parameter int PAY_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din_i,
    input  logic              clr_i,
    input  logic              type_en_i,
    input  logic              pay_en_i,
    output logic [TYPE_W-1:0] type_q,
    output logic [PAY_W-1:0]  pay_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            type_q <= '0;
            pay_q  <= '0;
        end else if (clr_i) begin
            type_q <= '0;
            pay_q  <= '0;
        end else begin
            if (type_en_i) type_q <= {type_q[TYPE_W-2:0], din_i};
            if (pay_en_i)  pay_q  <= {pay_q[PAY_W-2:0], din_i};
        end
    end
endmodule

// File: rtl/lrq_fsm.sv
module lrq_fsm
    import lrq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din_i,
    input  lrq_kind_e        kind_now_i,
    input  logic [CNT_W-1:0] last_now_i,
    output lrq_kind_e        kind_q,
    output logic             clr_o,
    output logic             type_en_o,
    output logic             pay_en_o,
    output logic             stop_chk_o,
    output logic             type_bad_o
);
    lrq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             type_last;

    assign type_last = (cnt_q == CNT_W'(TYPE_W - 1));

    // Next state and bit counter.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_HUNT: begin
                cnt_d = '0;
                if (din_i) state_d = ST_TYPE;
            end
            ST_TYPE: begin
                if (type_last) begin
                    cnt_d   = last_now_i;
                    state_d = (kind_now_i == K_RSVD) ? ST_DRAIN : ST_BODY;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_BODY: begin
                cnt_d = cnt_q - 1'b1;
                if (cnt_q == '0) state_d = ST_STOP;
            end
            ST_STOP: begin
                cnt_d   = '0;
                state_d = din_i ? ST_DRAIN : ST_HUNT;
            end
            ST_DRAIN: begin
                cnt_d = '0;
                if (!din_i) state_d = ST_HUNT;
            end
            default: begin
                cnt_d   = '0;
                state_d = ST_HUNT;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
            kind_q  <= K_BUS;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (state_q == ST_TYPE && type_last) kind_q <= kind_now_i;
        end
    end

    // Control outputs.
    always_comb begin
        clr_o      = 1'b0;
        type_en_o  = 1'b0;
        pay_en_o   = 1'b0;
        stop_chk_o = 1'b0;
        type_bad_o = 1'b0;
        unique case (state_q)
            ST_HUNT:  clr_o = din_i;
            ST_TYPE: begin
                type_en_o  = 1'b1;
                type_bad_o = type_last && (kind_now_i == K_RSVD);
            end
            ST_BODY:  pay_en_o   = 1'b1;
            ST_STOP:  stop_chk_o = 1'b1;
            default: ;
        endcase
    end

    // R9: a high sample in HUNT always opens a frame on the next edge
    a_r9_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT && din_i) |=> (state_q == ST_TYPE));

    // R6: DRAIN keeps ignoring the line while it stays high
    a_r6_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && din_i) |=> (state_q == ST_DRAIN));

    // R7: a high stop sample never returns straight to HUNT
    a_r7_stop_high_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && din_i) |=> (state_q == ST_DRAIN));
endmodule

// File: rtl/lrq_outreg.sv
module lrq_outreg
    import lrq_pkg::*;
#(
    parameter int SPD_W  = 2,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int PAY_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din_i,
    input  logic              stop_chk_i,
    input  logic              type_bad_i,
    input  lrq_kind_e         kind_i,
    input  logic [TYPE_W-1:0] type_i,
    input  logic [PAY_W-1:0]  pay_i,
    output logic              valid_o,
    output logic [TYPE_W-1:0] type_o,
    output logic [SPD_W-1:0]  speed_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              type_err_o,
    output logic              frame_err_o
);
    logic good;
    assign good = stop_chk_i && !din_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o     <= 1'b0;
            type_err_o  <= 1'b0;
            frame_err_o <= 1'b0;
            type_o      <= '0;
            speed_o     <= '0;
            addr_o      <= '0;
            data_o      <= '0;
        end else begin
            valid_o     <= good;
            type_err_o  <= type_bad_i;
            frame_err_o <= stop_chk_i && din_i;
            if (good) begin
                type_o  <= type_i;
                speed_o <= '0;
                addr_o  <= '0;
                data_o  <= '0;
                unique case (kind_i)
                    K_BUS:   speed_o <= pay_i[SPD_W-1:0];
                    K_READ:  addr_o  <= pay_i[ADDR_W-1:0];
                    K_WRITE: begin
                        addr_o <= pay_i[ADDR_W+DATA_W-1:DATA_W];
                        data_o <= pay_i[DATA_W-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: the strobe is a single-cycle pulse
    a_r11_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R11: strobe and error pulses are mutually exclusive
    a_r11_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({valid_o, type_err_o, frame_err_o}));

    // R8: fields only move together with the strobe
    a_r8_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(type_o) && $stable(speed_o) && $stable(addr_o) && $stable(data_o)));
endmodule

// File: rtl/lreq_frame_decoder.sv
module lreq_frame_decoder
    import lrq_pkg::*;
#(
    parameter int SPD_W  = 2,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lreq_in,
    output logic              req_valid_o,
    output logic [2:0]        req_type_o,
    output logic [SPD_W-1:0]  req_speed_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_data_o,
    output logic              type_err_o,
    output logic              frame_err_o
);
    localparam int PAY_W = ADDR_W + DATA_W;
    localparam int CNT_W = ($clog2(PAY_W) < 2) ? 2 : $clog2(PAY_W);

    logic [TYPE_W-1:0] type_q;
    logic [PAY_W-1:0]  pay_q;
    logic [TYPE_W-1:0] code_now;
    logic [CNT_W-1:0]  last_now;
    lrq_kind_e         kind_now, kind_q;
    logic              clr, type_en, pay_en, stop_chk, type_bad;

    // Type code as it stands once the current bit is included.
    assign code_now = {type_q[TYPE_W-2:0], lreq_in};

    lrq_classify #(
        .SPD_W(SPD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_classify (
        .code_i (code_now),
        .kind_o (kind_now),
        .last_o (last_now)
    );

    lrq_shifter #(.PAY_W(PAY_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .din_i     (lreq_in),
        .clr_i     (clr),
        .type_en_i (type_en),
        .pay_en_i  (pay_en),
        .type_q    (type_q),
        .pay_q     (pay_q)
    );

    lrq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .din_i      (lreq_in),
        .kind_now_i (kind_now),
        .last_now_i (last_now),
        .kind_q     (kind_q),
        .clr_o      (clr),
        .type_en_o  (type_en),
        .pay_en_o   (pay_en),
        .stop_chk_o (stop_chk),
        .type_bad_o (type_bad)
    );

    lrq_outreg #(
        .SPD_W(SPD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAY_W(PAY_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .din_i       (lreq_in),
        .stop_chk_i  (stop_chk),
        .type_bad_i  (type_bad),
        .kind_i      (kind_q),
        .type_i      (type_q),
        .pay_i       (pay_q),
        .valid_o     (req_valid_o),
        .type_o      (req_type_o),
        .speed_o     (req_speed_o),
        .addr_o      (reg_addr_o),
        .data_o      (reg_data_o),
        .type_err_o  (type_err_o),
        .frame_err_o (frame_err_o)
    );
endmodule

// File: tb/sim_lreq_frame_decoder.sv
`timescale 1ns/1ps
module sim_lreq_frame_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       din = 1'b0;
    logic       vld, terr, ferr;
    logic [2:0] rtype;
    logic [1:0] spd;
    logic [3:0] addr;
    logic [7:0] data;

    lreq_frame_decoder u0 (
        .clk(clk), .rst_n(rst_n), .lreq_in(din),
        .req_valid_o(vld), .req_type_o(rtype), .req_speed_o(spd),
        .reg_addr_o(addr), .reg_data_o(data),
        .type_err_o(terr), .frame_err_o(ferr)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0, n_errs = 0;
    int n_val = 0, n_terr = 0, n_ferr = 0, terr_cyc = -1, ferr_cyc = -1;
    logic [16:0] cap [64];
    int cap_cyc [64];

    // Monitor samples outputs on the falling edge.
    always @(negedge clk) begin
        if (vld && n_val < 64) begin
            cap[n_val]     = {rtype, spd, addr, data};
            cap_cyc[n_val] = cyc;
        end
        if (vld)  n_val++;
        if (terr) begin n_terr++; terr_cyc = cyc; end
        if (ferr) begin n_ferr++; ferr_cyc = cyc; end
    end

    // Entries: {type, speed, addr, data}; fields a frame does not carry are junk here.
    localparam logic [16:0] TBL [8] = '{
        {3'b000, 2'b10, 4'hA, 8'h5C},
        {3'b001, 2'b01, 4'h3, 8'hFF},
        {3'b010, 2'b11, 4'h0, 8'h00},
        {3'b011, 2'b00, 4'hF, 8'h12},
        {3'b100, 2'b11, 4'hA, 8'h77},
        {3'b101, 2'b10, 4'h5, 8'hC3},
        {3'b101, 2'b00, 4'hF, 8'h81},
        {3'b100, 2'b01, 4'h3, 8'hEE}
    };

    function automatic logic [16:0] expect_of(input logic [16:0] e);
        logic [2:0] t;
        t = e[16:14];
        if (!t[2])          return {t, e[13:12], 4'h0, 8'h00};
        else if (t == 3'b100) return {t, 2'b00, e[11:8], 8'h00};
        else                return {t, 2'b00, e[11:8], e[7:0]};
    endfunction

    function automatic string tag_of(input logic [2:0] t);
        if (!t[2]) return "R2";
        else if (t == 3'b100) return "R3";
        else return "R4";
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic drive(input logic b);
        @(negedge clk);
        din = b;
    endtask

    task automatic send(input logic [16:0] e, input logic stopv, output int stop_cyc);
        logic [16:0] fr;
        int len;
        fr = '0;
        fr[16] = 1'b1;
        fr[15:13] = e[16:14];
        if (!e[16]) begin
            fr[12:11] = e[13:12]; fr[10] = stopv; len = 7;
        end else if (e[16:14] == 3'b100) begin
            fr[12:9] = e[11:8]; fr[8] = stopv; len = 9;
        end else begin
            fr[12:9] = e[11:8]; fr[8:1] = e[7:0]; fr[0] = stopv; len = 17;
        end
        for (int i = 0; i < len; i++) drive(fr[16-i]);
        stop_cyc = cyc;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        summary();
        $finish;
    end

    initial begin
        int sc;
        int exp_cyc [8];
        int base;
        logic [16:0] last_exp;

        // R1: outputs during reset
        repeat (3) @(negedge clk);
        chk({vld, terr, ferr, rtype, spd, addr, data} == '0, "R1 reset outputs",
            int'({rtype, spd, addr, data}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: idle line
        repeat (12) drive(1'b0);
        chk(n_val == 0 && n_terr == 0 && n_ferr == 0, "R10 idle quiet",
            n_val + n_terr + n_ferr, 0);

        // Table walk; most frames back to back (R9)
        for (int i = 0; i < 8; i++) begin
            if (i % 3 == 0) begin drive(1'b0); drive(1'b0); end
            send(TBL[i], 1'b0, sc);
            exp_cyc[i] = sc + 1;
        end
        repeat (4) drive(1'b0);
        chk(n_val == 8, "R11 one strobe per frame", n_val, 8);
        for (int i = 0; i < 8; i++) begin
            logic [16:0] ex;
            ex = expect_of(TBL[i]);
            chk(cap[i] == ex, tag_of(TBL[i][16:14]), int'(cap[i]), int'(ex));
            chk(cap[i][16:14] == TBL[i][16:14], "R5 type code", int'(cap[i][16:14]),
                int'(TBL[i][16:14]));
            chk(cap_cyc[i] == exp_cyc[i], (i % 3 == 0) ? "R2 strobe timing" : "R9 back-to-back timing",
                cap_cyc[i], exp_cyc[i]);
        end

        // R8: hold through idle
        last_exp = expect_of(TBL[7]);
        repeat (6) drive(1'b0);
        chk({rtype, spd, addr, data} == last_exp, "R8 hold idle",
            int'({rtype, spd, addr, data}), int'(last_exp));

        // R6: reserved code 110, junk highs, one low, then a good frame
        base = n_val;
        drive(1'b1); drive(1'b1); drive(1'b1); drive(1'b0);
        sc = cyc;
        repeat (5) drive(1'b1);
        chk(n_terr == 1 && terr_cyc == sc + 1, "R6 type error pulse", terr_cyc, sc + 1);
        chk(n_val == base && n_ferr == 0, "R6 no strobe after reserved", n_val - base, 0);
        chk({rtype, spd, addr, data} == last_exp, "R8 hold after type error",
            int'({rtype, spd, addr, data}), int'(last_exp));
        drive(1'b0);
        send({3'b010, 2'b01, 4'h0, 8'h00}, 1'b0, sc);
        drive(1'b0); drive(1'b0);
        chk(n_val == base + 1 && cap[base] == {3'b010, 2'b01, 12'h000},
            "R6 recovery frame", int'(cap[base]), int'({3'b010, 2'b01, 12'h000}));

        // R7: high stop bit, junk highs, one low, then a read frame
        last_exp = {3'b010, 2'b01, 12'h000};
        base = n_val;
        send({3'b011, 2'b11, 4'h0, 8'h00}, 1'b1, sc);
        drive(1'b1); drive(1'b1);
        chk(n_ferr == 1 && ferr_cyc == sc + 1, "R7 framing error pulse", ferr_cyc, sc + 1);
        chk(n_val == base, "R7 no strobe on bad stop", n_val - base, 0);
        chk({rtype, spd, addr, data} == last_exp, "R8 hold after framing error",
            int'({rtype, spd, addr, data}), int'(last_exp));
        drive(1'b0);
        send({3'b100, 2'b00, 4'h6, 8'h00}, 1'b0, sc);
        drive(1'b0); drive(1'b0);
        chk(n_val == base + 1 && cap[base] == {3'b100, 2'b00, 4'h6, 8'h00} &&
            cap_cyc[base] == sc + 1, "R7 recovery read frame", int'(cap[base]),
            int'({3'b100, 2'b00, 4'h6, 8'h00}));
        chk(n_terr == 1, "R6 no stray type error", n_terr, 1);

        // R1: asynchronous reset in the middle of a frame
        drive(1'b1); drive(1'b1); drive(1'b0);
        #5 rst_n = 1'b0;
        #2;
        chk({vld, terr, ferr, rtype, spd, addr, data} == '0, "R1 async clear",
            int'({rtype, spd, addr, data}), 0);
        din = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        base = n_val;
        drive(1'b0);
        send({3'b101, 2'b00, 4'h9, 8'h7E}, 1'b0, sc);
        drive(1'b0); drive(1'b0);
        chk(n_val == base + 1 && cap[base] == {3'b101, 2'b00, 4'h9, 8'h7E},
            "R4 write after reset", int'(cap[base]), int'({3'b101, 2'b00, 4'h9, 8'h7E}));

        summary();
        $finish;
    end
endmodule